// File: doc/BRIEF.md
# Bidirectional General-Purpose I/O Port

An eight-bit I/O port that sits on a small processor register bus. Software sets each pin's direction, writes the value to be driven into an output latch and samples the pin levels. The pins go out as a per-bit output value and a per-bit output enable, so the pad ring builds the tri-state buffers. Pin levels come in through a two-flop synchronizer.

Reads of the pin register and reads of the latch register take separate paths. A read-modify-write sequence on the latch therefore works on the driven value and not on whatever the pads show. External configuration logic supplies two inputs. The analog-enable mask forces pin reads of the selected bits to zero. The oscillator-mode flag takes over the two top pins: every read of those bits returns zero and their drivers are switched off. Bit 4 is open-drain: it can only pull its pin low.

Register map (2-bit address): 0 = pin levels (a write goes to the latch), 1 = output latch, 2 = direction (1 = input, 0 = output), 3 = unused.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction register holds all ones (every output enable low), the latch holds zero and the read data output is zero.
- R2: A write to address 2 loads the direction register, and a read of address 2 returns the value that was written.
- R3: For an ordinary bit, the output enable is the inverse of that bit's direction bit, and the output value equals the latch bit.
- R4: A write to address 0 or to address 1 loads the latch. A read of address 1 returns the latch whatever the pin levels are.
- R5: A read of address 0 returns the pin levels after a two-flop synchronizer. A pin change made in the same cycle as the read strobe is not seen by that read. It is seen by a strobe issued three or more cycles after the change.
- R6: A bit set in the analog-enable mask reads as zero at address 0. That bit's latch reads and its output enable are unchanged, and the direction register still controls the enable.
- R7: While oscillator mode is high, bits 7 and 6 read as zero at addresses 0, 1 and 2, and their output enables are low. Their stored direction and latch bits are kept and can be read again once the mode drops.
- R8: Bit 4 is open-drain. Its output value is always 0, and its output enable is high only when its direction bit is 0 and its latch bit is 0.
- R9: Read data appears on the read data output at the clock edge that samples the read strobe. It holds that value until the next strobe.
- R10: A read of address 3 returns zero. A write to address 3 changes neither the latch nor the direction register.
- R11: When a read and a write of the same register fall in the same cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| pin_i | input | 8 | Pad input levels (asynchronous) |
| pin_o | output | 8 | Pad output values |
| pin_oe_o | output | 8 | Pad output enables, 1 = drive |
| ana_en_i | input | 8 | Analog-enable mask, 1 = bit reads zero at address 0 |
| osc_mode_i | input | 1 | Oscillator mode, takes over bits 7 and 6 |

## Verification
The assertions assume that a read strobe and a write strobe never target different addresses in the same cycle. They also assume that the analog mask and the oscillator flag are quasi-static configuration inputs. Both are sampled together with the read strobe, so the stimulus changes them only between bus transactions. The bench changes pin levels and waits three cycles before a read, except in the one case that deliberately checks how late a pin change becomes visible. Every bus strobe and every configuration change is driven on the falling edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_PIN = 2'd0,
    REG_LAT = 2'd1,
    REG_DIR = 2'd2,
    REG_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] pin_sync_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[STAGES-2:0], pin_i};
  end

  assign pin_sync_o = stg_q[STAGES-1];

  initial begin
    AST_SYNC_DEPTH: assert (STAGES >= 2); // R5
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  dir_o,
  output logic [WIDTH-1:0]  lat_o
);
  logic hit_lat, hit_dir;

  assign hit_lat = wr_i && (addr_i == REG_PIN || addr_i == REG_LAT);
  assign hit_dir = wr_i && (addr_i == REG_DIR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o <= '1;
      lat_o <= '0;
    end else begin
      if (hit_lat) lat_o <= wdata_i;
      if (hit_dir) dir_o <= wdata_i;
    end
  end

  AST_DIR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == REG_DIR) |=> (dir_o == $past(wdata_i))); // R2
  AST_LAT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (addr_i == REG_PIN || addr_i == REG_LAT)) |=> (lat_o == $past(wdata_i))); // R4
  AST_NONE_KEEPS_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == REG_NONE) |=> $stable(lat_o)); // R10
  AST_NONE_KEEPS_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == REG_NONE) |=> $stable(dir_o)); // R10
endmodule

// File: rtl/gpio_drive.sv
module gpio_drive #(
  parameter int WIDTH  = 8,
  parameter int OD_BIT = 4,
  parameter int OSC_HI = 7,
  parameter int OSC_LO = 6
) (
  input  logic [WIDTH-1:0] dir_i,
  input  logic [WIDTH-1:0] lat_i,
  input  logic             osc_mode_i,
  output logic [WIDTH-1:0] pin_o,
  output logic [WIDTH-1:0] pin_oe_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == OD_BIT) begin : g_od
      // pull low only; latch 1 releases the pad
      assign pin_o[i]    = 1'b0;
      assign pin_oe_o[i] = ~dir_i[i] & ~lat_i[i];
    end else if (i == OSC_HI || i == OSC_LO) begin : g_osc
      assign pin_o[i]    = lat_i[i];
      assign pin_oe_o[i] = ~dir_i[i] & ~osc_mode_i;
    end else begin : g_pp
      assign pin_o[i]    = lat_i[i];
      assign pin_oe_o[i] = ~dir_i[i];
    end
  end
endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux
  import gpio_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int OSC_HI = 7,
  parameter int OSC_LO = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  pin_sync_i,
  input  logic [WIDTH-1:0]  lat_i,
  input  logic [WIDTH-1:0]  dir_i,
  input  logic [WIDTH-1:0]  ana_en_i,
  input  logic              osc_mode_i,
  output logic [WIDTH-1:0]  rdata_o
);
  localparam logic [WIDTH-1:0] OSC_MASK =
    (WIDTH'(1) << OSC_HI) | (WIDTH'(1) << OSC_LO);

  logic [WIDTH-1:0] keep_mask, rd_mux;

  assign keep_mask = osc_mode_i ? ~OSC_MASK : '1;

  always_comb begin
    unique case (reg_addr_e'(addr_i))
      REG_PIN: rd_mux = pin_sync_i & ~ana_en_i & keep_mask;
      REG_LAT: rd_mux = lat_i & keep_mask;
      REG_DIR: rd_mux = dir_i & keep_mask;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_mux;
  end

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o)); // R9
  AST_NONE_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == REG_NONE) |=> (rdata_o == '0)); // R10
  AST_ANALOG_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == REG_PIN) |=> ((rdata_o & $past(ana_en_i)) == '0)); // R6
  AST_OSC_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && osc_mode_i) |=> ((rdata_o & OSC_MASK) == '0)); // R7
  AST_LAT_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == REG_LAT && !osc_mode_i) |=> (rdata_o == $past(lat_i))); // R4
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int OD_BIT      = 4,
  parameter int OSC_HI      = 7,
  parameter int OSC_LO      = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  rdata_o,
  input  logic [WIDTH-1:0]  pin_i,
  output logic [WIDTH-1:0]  pin_o,
  output logic [WIDTH-1:0]  pin_oe_o,
  input  logic [WIDTH-1:0]  ana_en_i,
  input  logic              osc_mode_i
);
  logic [WIDTH-1:0] dir_q, lat_q, pin_sync;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i), .pin_sync_o(pin_sync)
  );

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .dir_o(dir_q), .lat_o(lat_q)
  );

  gpio_drive #(.WIDTH(WIDTH), .OD_BIT(OD_BIT), .OSC_HI(OSC_HI), .OSC_LO(OSC_LO)) u_drive (
    .dir_i(dir_q), .lat_i(lat_q), .osc_mode_i(osc_mode_i),
    .pin_o(pin_o), .pin_oe_o(pin_oe_o)
  );

  gpio_rdmux #(.WIDTH(WIDTH), .OSC_HI(OSC_HI), .OSC_LO(OSC_LO)) u_rdmux (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_i), .addr_i(addr_i),
    .pin_sync_i(pin_sync), .lat_i(lat_q), .dir_i(dir_q),
    .ana_en_i(ana_en_i), .osc_mode_i(osc_mode_i), .rdata_o(rdata_o)
  );

  AST_OD_NO_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_oe_o[OD_BIT] |-> (!pin_o[OD_BIT] && !lat_q[OD_BIT] && !dir_q[OD_BIT])); // R8
  AST_OSC_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_mode_i |-> (!pin_oe_o[OSC_HI] && !pin_oe_o[OSC_LO])); // R7
  AST_INPUT_UNDRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pin_oe_o & dir_q) == '0)); // R3
endmodule

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0, rdata, pin_in = '0, pin_out, pin_oe, ana_en = '0;
  logic       osc = 1'b0;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         done = 1'b0;

  always #4 clk = ~clk;

  gpio_port dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin_in), .pin_o(pin_out),
    .pin_oe_o(pin_oe), .ana_en_i(ana_en), .osc_mode_i(osc)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); addr = a; rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); rd = 1'b0;
  endtask

  // R5: pin changes in the same cycle as the strobe
  task automatic rd_pin_change(input logic [7:0] p, input logic [7:0] exp, input string tag);
    @(negedge clk); addr = 2'd0; rd = 1'b1; pin_in = p;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); rd = 1'b0;
  endtask

  // R11: read and write same register in the same cycle
  task automatic rw_reg(input logic [1:0] a, input logic [7:0] d, input logic [7:0] exp, input string tag);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1; rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); wr = 1'b0; rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: scoreboard pop on each sampled read strobe
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && rd) begin
        #1;
        if (exp_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R9: actual %02h expected <none queued>", rdata);
        end else chk(rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    chk(rdata, 8'h00, "R1 rdata");
    chk(pin_oe, 8'h00, "R1 oe");
    rd_reg(2'd2, 8'hFF, "R1 dir");
    rd_reg(2'd1, 8'h00, "R1 lat");

    wr_reg(2'd2, 8'h00);
    rd_reg(2'd2, 8'h00, "R2 dir");
    chk(pin_oe, 8'hFF, "R3 oe all out");
    chk(pin_out, 8'h00, "R3 pin_o");

    wr_reg(2'd1, 8'hA5);
    chk(pin_out, 8'hA5, "R3 pin_o A5");
    chk(pin_oe, 8'hFF, "R8 od pull low");
    rd_reg(2'd1, 8'hA5, "R4 lat read");

    wr_reg(2'd0, 8'h5A);
    rd_reg(2'd1, 8'h5A, "R4 lat via pin addr");
    chk(pin_out, 8'h4A, "R8 od value zero");
    chk(pin_oe, 8'hEF, "R8 od released");

    wr_reg(2'd2, 8'hF0);
    chk(pin_oe, 8'h0F, "R3 oe mixed");

    pin_in = 8'h3C; idle(3);
    rd_reg(2'd0, 8'h3C, "R5 pin read");
    rd_pin_change(8'hC3, 8'h3C, "R5 sync latency");
    idle(3);
    rd_reg(2'd0, 8'hC3, "R5 pin settled");

    ana_en = 8'h2F; pin_in = 8'hFF; idle(3);
    rd_reg(2'd0, 8'hD0, "R6 analog zero");
    rd_reg(2'd1, 8'h5A, "R6 lat unaffected");
    chk(pin_oe, 8'h0F, "R6 dir still drives");
    ana_en = 8'h00;

    @(negedge clk); osc = 1'b1;
    wr_reg(2'd2, 8'h00);
    chk(pin_oe, 8'h2F, "R7 osc no drive");
    rd_reg(2'd0, 8'h3F, "R7 pin masked");
    rd_reg(2'd1, 8'h1A, "R7 lat masked");
    wr_reg(2'd2, 8'hC3);
    rd_reg(2'd2, 8'h03, "R7 dir masked");
    @(negedge clk); osc = 1'b0;
    rd_reg(2'd2, 8'hC3, "R7 dir kept");
    idle(4);
    chk(rdata, 8'hC3, "R9 rdata held");

    wr_reg(2'd3, 8'h12);
    rd_reg(2'd2, 8'hC3, "R10 dir untouched");
    rd_reg(2'd1, 8'h5A, "R10 lat untouched");
    rd_reg(2'd3, 8'h00, "R10 unused reads zero");

    rw_reg(2'd1, 8'h77, 8'h5A, "R11 old value");
    rd_reg(2'd1, 8'h77, "R11 new value");

    idle(3);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R9: actual %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule